// File: doc/BRIEF.md
# Double-Error-Correcting Check-Bit Encoder for 16-Bit Words

This block turns a 16-bit data word into a 26-bit codeword of a binary BCH code that corrects any two bit errors. The code is the (31,21) cyclic BCH code with generator polynomial g(x) = x^10 + x^9 + x^8 + x^6 + x^5 + x^3 + 1, shortened to 16 data bits. The data bits pass into the codeword unchanged. Ten check bits are appended, and the whole codeword is written to memory. A matching decoder on the read path recomputes the same check bits to form a syndrome.

Each check bit is an XOR tree over the data bits selected by one column of the parity sub-matrix. That sub-matrix is not typed in by hand. A constant function builds it at elaboration by dividing x^(10+i) by g(x) for every kept data row i. Shortening keeps rows 0 to 15 and drops the rest. The encoder output can be registered (parameter `OUT_REG`, default 1), which gives one cycle of latency, or left purely combinational.

Top module: `bch_check_encoder`

## Requirements
- R1: The codeword field code_out[25:10] equals the data word presented one cycle earlier, bit for bit.
- R2: The check field code_out[9:0] holds the coefficients of x^9..x^0 of the remainder of d(x)·x^10 divided by g(x) over GF(2). Here d(x) has data bit i as the coefficient of x^i, and g(x) = x^10+x^9+x^8+x^6+x^5+x^3+1.
- R3: Every codeword on code_out, read as a polynomial with bit t as the coefficient of x^t, leaves a zero remainder when divided by g(x). This is the zero syndrome the decoder expects.
- R4: The encoding is linear: the codeword of a XOR b equals the XOR of the codewords of a and b.
- R5: Every nonzero data word encodes to a codeword with at least five 1 bits.
- R6: While rst_n is low, code_out is all zeros whatever data_in holds.
- R7: A data word with only bit 0 set gives check bits 10'h369.
- R8: An all-zero data word gives an all-zero codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_in | input | 16 | Data word to be encoded |
| code_out | output | 26 | Codeword: data in [25:10], check bits in [9:0] |

## Verification
Each of the sixteen single-bit data words is checked on its own, because a wrong entry in one parity row shows up only when that data bit is set. A wrong row gives a check field that fails the remainder test against g(x).

The all-ones word and alternating patterns exercise every XOR tree at full fan-in. A column that picks up one bit too many or too few breaks linearity or the divisibility check.

Random words are checked for minimum weight. A table built from the wrong polynomial, or with the wrong row offset, yields low-weight codewords that a two-error decoder could not separate.

Reset is applied in the middle of a run with a nonzero input present, to catch an output register that reloads data while reset is held.

// File: rtl/bch_check_encoder.sv
module bch_check_encoder #(
  parameter int DATA_W = 16,
  parameter int CHK_W = 10,
  parameter logic [CHK_W:0] GEN_POLY = 11'h769,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         data_in,
  output logic [DATA_W+CHK_W-1:0]   code_out
);
  localparam int CW_W = DATA_W + CHK_W;

  function automatic logic [DATA_W-1:0][CHK_W-1:0] build_rows();
    logic [DATA_W-1:0][CHK_W-1:0] rows;
    logic [CHK_W-1:0] rem;
    logic [CHK_W:0] nxt;
    rem = GEN_POLY[CHK_W-1:0];
    for (int i = 0; i < DATA_W; i++) begin
      rows[i] = rem;
      nxt = {rem, 1'b0};
      if (nxt[CHK_W]) nxt = nxt ^ GEN_POLY;
      rem = nxt[CHK_W-1:0];
    end
    return rows;
  endfunction

  localparam logic [DATA_W-1:0][CHK_W-1:0] ROWS = build_rows();

  function automatic logic [DATA_W-1:0] column(int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ROWS[i][j];
    return m;
  endfunction

  logic [CHK_W-1:0] chk;
  logic [CW_W-1:0]  cw;

  for (genvar j = 0; j < CHK_W; j++) begin : g_tree
    localparam logic [DATA_W-1:0] MASK = column(j);
    assign chk[j] = ^(data_in & MASK);
  end

  assign cw = {data_in, chk};

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) code_out <= '0;
      else        code_out <= cw;
  end else begin : g_comb
    assign code_out = cw;
  end
endmodule

module bch_enc_chk #(
  parameter int DATA_W = 16,
  parameter int CHK_W = 10,
  parameter logic [CHK_W:0] GEN_POLY = 11'h769,
  parameter bit OUT_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DATA_W-1:0]       data_in,
  input logic [DATA_W+CHK_W-1:0] code_out
);
  localparam int CW_W = DATA_W + CHK_W;

  function automatic logic [CHK_W-1:0] rem_of(logic [CW_W-1:0] w);
    logic [CHK_W:0] acc;
    acc = '0;
    for (int t = CW_W - 1; t >= 0; t--) begin
      acc = {acc[CHK_W-1:0], w[t]};
      if (acc[CHK_W]) acc = acc ^ GEN_POLY;
    end
    return acc[CHK_W-1:0];
  endfunction

  // R3
  zero_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_of(code_out) == '0);

  if (OUT_REG) begin : g_seq
    logic primed;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;

    // R1
    data_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> code_out[CW_W-1:CHK_W] == $past(data_in));
    // R5
    min_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(data_in) != '0) |-> $countones(code_out) >= 5);
    // R8
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_in == '0) |=> code_out == '0);
    // R6
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> code_out == '0);
  end else begin : g_cmb
    always_comb begin
      // R1
      data_passthru_chk: assert (code_out[CW_W-1:CHK_W] == data_in);
      // R8
      zero_word_chk: assert (data_in != '0 || code_out == '0);
    end
  end
endmodule

bind bch_check_encoder bch_enc_chk #(
  .DATA_W(DATA_W), .CHK_W(CHK_W), .GEN_POLY(GEN_POLY), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .code_out(code_out)
);

// File: tb/sim_bch_check_encoder.sv
module sim_bch_check_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data_in = '0;
  logic [25:0] code_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bch_check_encoder u0 (.clk(clk), .rst_n(rst_n), .data_in(data_in), .code_out(code_out));

  function automatic logic [9:0] bench_rem(logic [25:0] w);
    logic [10:0] acc = '0;
    for (int t = 25; t >= 0; t--) begin
      acc = {acc[9:0], w[t]};
      if (acc[10]) acc = acc ^ 11'h769;
    end
    return acc[9:0];
  endfunction

  function automatic logic [25:0] bench_code(logic [15:0] d);
    return {d, bench_rem({d, 10'b0})};
  endfunction

  task automatic chk(bit ok, string req, logic [25:0] act, logic [25:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enc(input logic [15:0] d, output logic [25:0] cw);
    @(negedge clk) data_in = d;
    @(negedge clk) cw = code_out;
  endtask

  task automatic full_check(input logic [15:0] d);
    logic [25:0] cw;
    enc(d, cw);
    chk(cw[25:10] == d, "R1", {10'b0, cw[25:10]}, {10'b0, d});
    chk(cw[9:0] == bench_rem({d, 10'b0}), "R2", cw, bench_code(d));
    chk(bench_rem(cw) == '0, "R3", {16'b0, bench_rem(cw)}, '0);
    if (d != '0)
      chk($countones(cw) >= 5, "R5", $countones(cw), 5);
  endtask

  initial begin
    logic [25:0] ca, cb, cx;
    void'($urandom(32'd1234));
    data_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(code_out == '0, "R6", code_out, '0);
    rst_n = 1'b1;

    enc(16'h0000, cx);
    chk(cx == '0, "R8", cx, '0);
    enc(16'h0001, cx);
    chk(cx[9:0] == 10'h369, "R7", {16'b0, cx[9:0]}, 26'h369);
    for (int i = 0; i < 16; i++) full_check(16'h1 << i);
    full_check(16'hFFFF);
    full_check(16'hAAAA);
    full_check(16'h5555);
    full_check(16'h8001);
    for (int n = 0; n < 1500; n++) full_check(16'($urandom));

    for (int n = 0; n < 200; n++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      enc(a, ca);
      enc(b, cb);
      enc(a ^ b, cx);
      chk(cx == (ca ^ cb), "R4", cx, ca ^ cb);
    end

    @(negedge clk) data_in = 16'hC3A5;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(code_out == '0, "R6", code_out, '0);
    rst_n = 1'b1;
    full_check(16'hC3A5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule